// File: doc/BRIEF.md
# SMBus Temperature Sensor Slave

This block is the serial front end of a digital temperature sensor. It watches a two-wire SMBus (clock and data), both sampled by the system clock. It answers only its own fixed 7-bit device address. Through it a host selects one of two byte registers with a command byte: the latest temperature value, or a configuration byte. The host can write the configuration byte and read either register. The device is always a slave. It never drives the clock, and it pulls the data line low only through an open-drain enable.

The temperature value comes from an abstracted converter. The converter presents an 8-bit two's-complement reading together with a one-cycle valid pulse. A standby bit in the configuration byte drops the converter-enable output and freezes the stored temperature. While in standby, every bus access is still decoded and answered as usual.

Top module: `smb_therm_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1001101b. Bit 0 selects read (1) or write (0). After any other address it drives nothing until the next START, including during the following bytes.
- R2: START is data falling while clock is high, and STOP is data rising while clock is high. A START in any state, even in mid-byte, restarts address reception. After a STOP, no byte is acknowledged until a new START.
- R3: After each accepted address, command or written data byte, the block holds the data line low for the whole high phase of the ninth clock.
- R4: The open-drain enable changes only while the clock is low, except for the release forced by START or STOP.
- R5: Command value 0x00 selects the temperature register and 0x01 selects the configuration register. A read returns the register chosen by the most recent command byte. A read after any other command value returns 0x00.
- R6: Read bytes go out MSB first. While the host acknowledges, further reads return the same selected register again.
- R7: When the host does not acknowledge a read byte, the block releases the data line and drives nothing more until STOP or START.
- R8: A written configuration byte keeps only bit 7 (standby), and the other bits read back as 0. A data write after any other command value is acknowledged and has no effect.
- R9: With standby set, the converter-enable output is low and the temperature register ignores valid pulses. Bus accesses are still answered normally.
- R10: In normal mode the temperature register loads the input on each valid pulse. A load during a read of that byte does not change the byte being sent; the next byte carries the new value.
- R11: After reset the data line is released, the converter is enabled, and both registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | When high, pull the data line low |
| temp_in | input | 8 | Converter reading, two's complement |
| temp_vld | input | 1 | One-cycle pulse: temp_in holds a new reading |
| conv_en | output | 1 | High while the converter should acquire |

## Verification
Assertions check on every cycle these rules: the data enable stays still while the clock is high; START always leads to address reception and STOP always leads to idle with the line released; the line is held low in every acknowledge phase and never driven while idle or after a host NACK; the temperature register freezes in standby and loads on a valid pulse in normal mode. Only the bench's scenarios can show the byte-level results: which addresses receive an acknowledge, what value each command returns, the config bit masking, an ignored write, a START cut into a half-sent byte, and the snapshot taken when a reading arrives in the middle of a read.

// File: rtl/smb_therm_slave.sv
`timescale 1ns/1ps
module smb_therm_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'b1001101,
  parameter int         SYNC_STAGES = 2,
  parameter int         DW          = 8,
  parameter int         STBY_BIT    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [DW-1:0] temp_in,
  input  logic          temp_vld,
  output logic          conv_en
);

  localparam int            CW       = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);
  localparam logic [DW-1:0] CMD_TEMP = '0;
  localparam logic [DW-1:0] CMD_CFG  = DW'(1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_WAIT
  } st_t;

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic                   scl_q, sda_q;
  logic                   scl_s, sda_s;
  logic                   start_det, stop_det, scl_rise, scl_fall;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, ptr, temp_q, rd_val;
  logic          rw, stby, m_ack, oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;

  always_comb begin
    rd_val = '0;
    if (ptr == CMD_TEMP)     rd_val = temp_q;
    else if (ptr == CMD_CFG) rd_val[STBY_BIT] = stby;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                temp_q <= '0;
    else if (temp_vld && !stby) temp_q <= temp_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      ptr   <= CMD_TEMP;
      rw    <= 1'b0;
      stby  <= 1'b0;
      m_ack <= 1'b0;
      oe    <= 1'b0;
    end else if (start_det) begin
      st  <= ST_ADDR;
      cnt <= '0;
      oe  <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE;
      oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_CMD, ST_WR: begin
          if (scl_rise && cnt != CNT_FULL) begin
            sh  <= {sh[DW-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            cnt <= '0;
            if (st == ST_ADDR) begin
              if (sh[DW-1:1] == DEV_ADDR) begin
                rw <= sh[0];
                oe <= 1'b1;
                st <= ST_ADDR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              oe <= 1'b1;
              if (st == ST_CMD) begin
                ptr <= sh;
                st  <= ST_CMD_ACK;
              end else begin
                if (ptr == CMD_CFG) stby <= sh[STBY_BIT];
                st <= ST_WR_ACK;
              end
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          if (rw) begin
            sh  <= rd_val;
            oe  <= ~rd_val[DW-1];
            cnt <= '0;
            st  <= ST_RD;
          end else begin
            oe <= 1'b0;
            st <= ST_CMD;
          end
        end
        ST_CMD_ACK, ST_WR_ACK: if (scl_fall) begin
          oe <= 1'b0;
          st <= ST_WR;
        end
        ST_RD: if (scl_fall) begin
          if (cnt == CNT_LAST) begin
            oe <= 1'b0;
            st <= ST_RD_ACK;
          end else begin
            sh  <= {sh[DW-2:0], 1'b0};
            oe  <= ~sh[DW-2];
            cnt <= cnt + 1'b1;
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) m_ack <= ~sda_s;
          else if (scl_fall) begin
            if (m_ack) begin
              sh  <= rd_val;
              oe  <= ~rd_val[DW-1];
              cnt <= '0;
              st  <= ST_RD;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe  = oe;
  assign conv_en = ~stby;

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR && !sda_oe));
  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !sda_oe));
  // R4
  oe_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && !start_det && !stop_det) |=> $stable(sda_oe));
  // R3
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {ST_ADDR_ACK, ST_CMD_ACK, ST_WR_ACK}) |-> sda_oe);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
  // R7
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT || st == ST_RD_ACK) |-> !sda_oe);
  // R9
  stby_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> $stable(temp_q));
  // R10
  temp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_vld && !stby) |=> (temp_q == $past(temp_in)));

endmodule

// File: tb/smb_therm_slave_bench.sv
`timescale 1ns/1ps
module smb_therm_slave_bench;
  localparam int         Q   = 8;
  localparam logic [6:0] ADR = 7'b1001101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, temp_vld = 1'b0;
  logic [7:0] temp_in = 8'h00;
  logic       sda_oe, conv_en, sda_bus;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  smb_therm_slave u_smb_therm_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .temp_in(temp_in), .temp_vld(temp_vld), .conv_en(conv_en));

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask
  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask
  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~give_ack);
  endtask
  task automatic pulse(input logic [7:0] v);
    temp_in = v; temp_vld = 1'b1; tick(1); temp_vld = 1'b0; tick(1);
  endtask

  task automatic wr_reg(input string req, input logic [7:0] cmd, input logic [7:0] d);
    logic a;
    bus_start;
    send_byte({ADR, 1'b0}, a); check({req, " addr ack"}, a, 1);
    send_byte(cmd, a);         check({req, " cmd ack"}, a, 1);
    send_byte(d, a);           check({req, " data ack"}, a, 1);
    bus_stop;
  endtask
  task automatic rd_reg(input string req, input logic [7:0] cmd, output logic [7:0] d);
    logic a;
    bus_start;
    send_byte({ADR, 1'b0}, a); check({req, " addr ack"}, a, 1);
    send_byte(cmd, a);         check({req, " cmd ack"}, a, 1);
    bus_start;
    send_byte({ADR, 1'b1}, a); check({req, " read addr ack"}, a, 1);
    recv_byte(1'b0, d);
    bus_stop;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R11 oe", sda_oe, 0);
    check("R11 conv_en", conv_en, 1);
    rd_reg("R11", 8'h00, d); check("R11 temp", d, 8'h00);
    rd_reg("R11", 8'h01, d); check("R11 cfg", d, 8'h00);
  endtask

  task automatic t_temp_read;
    logic [7:0] d;
    pulse(8'h19);
    rd_reg("R5", 8'h00, d); check("R10 temp load", d, 8'h19);
  endtask

  task automatic t_multi_read;
    logic a, b; logic [7:0] d;
    pulse(8'hE7);
    bus_start;
    send_byte({ADR, 1'b0}, a); check("R3 addr", a, 1);
    send_byte(8'h00, a);       check("R3 cmd", a, 1);
    bus_stop;
    bus_start;
    send_byte({ADR, 1'b1}, a); check("R1 read addr", a, 1);
    recv_byte(1'b1, d); check("R6 byte0", d, 8'hE7);
    recv_byte(1'b1, d); check("R6 byte1", d, 8'hE7);
    recv_byte(1'b0, d); check("R6 byte2", d, 8'hE7);
    get_bit(b); check("R7 released bit", b, 1);
    check("R7 oe", sda_oe, 0);
    bus_stop;
  endtask

  task automatic t_wrong_addr;
    logic a;
    bus_start;
    send_byte({7'b1001100, 1'b0}, a); check("R1 wrong addr", a, 0);
    send_byte(8'h01, a);              check("R1 after miss", a, 0);
    send_byte(8'h80, a);              check("R1 after miss data", a, 0);
    bus_stop;
    check("R1 no write", conv_en, 1);
    bus_start;
    send_byte({7'b0001101, 1'b1}, a); check("R1 wrong read addr", a, 0);
    bus_stop;
  endtask

  task automatic t_config;
    logic [7:0] d;
    wr_reg("R8", 8'h01, 8'h80);
    check("R9 conv_en low", conv_en, 0);
    rd_reg("R8", 8'h01, d); check("R8 cfg read", d, 8'h80);
    pulse(8'h30);
    rd_reg("R9", 8'h00, d); check("R9 frozen", d, 8'hE7);
    wr_reg("R8", 8'h01, 8'h7F);
    check("R8 conv_en back", conv_en, 1);
    rd_reg("R8", 8'h01, d); check("R8 mask", d, 8'h00);
    rd_reg("R9", 8'h00, d); check("R9 still old", d, 8'hE7);
    pulse(8'h30);
    rd_reg("R10", 8'h00, d); check("R10 resumed", d, 8'h30);
  endtask

  task automatic t_ignored;
    logic [7:0] d;
    wr_reg("R8", 8'h05, 8'h80);
    check("R8 other cmd", conv_en, 1);
    wr_reg("R8", 8'h00, 8'h55);
    rd_reg("R8", 8'h00, d); check("R8 temp not written", d, 8'h30);
    rd_reg("R5", 8'h07, d); check("R5 other read", d, 8'h00);
  endtask

  task automatic t_mid_start;
    logic a;
    bus_start;
    send_byte({ADR, 1'b0}, a); check("R2 addr", a, 1);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start;
    send_byte({ADR, 1'b0}, a); check("R2 restart addr", a, 1);
    send_byte(8'h01, a);       check("R2 cmd", a, 1);
    send_byte(8'h80, a);       check("R2 data", a, 1);
    bus_stop;
    check("R2 write landed", conv_en, 0);
    send_byte({ADR, 1'b0}, a); check("R2 no start", a, 0);
    bus_stop;
    wr_reg("R2", 8'h01, 8'h00);
    check("R2 restored", conv_en, 1);
  endtask

  task automatic t_snapshot;
    logic a; logic [7:0] d;
    pulse(8'h11);
    bus_start;
    send_byte({ADR, 1'b0}, a); check("R10 addr", a, 1);
    send_byte(8'h00, a);       check("R10 cmd", a, 1);
    bus_start;
    send_byte({ADR, 1'b1}, a); check("R10 read addr", a, 1);
    fork
      recv_byte(1'b1, d);
      begin tick(12*Q); pulse(8'hA5); end
    join
    check("R10 snapshot", d, 8'h11);
    recv_byte(1'b0, d); check("R10 next byte", d, 8'hA5);
    bus_stop;
  endtask

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    t_reset;
    t_temp_read;
    t_multi_read;
    t_wrong_addr;
    t_config;
    t_ignored;
    t_mid_start;
    t_snapshot;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule